// File: doc/BRIEF.md
# Serial Bit Stuffing Inserter

This block sits on the transmit side of a bit-oriented link and makes the payload transparent to the framing flag. It watches a serial payload and counts consecutive 1s. Once a run of five 1s has been passed downstream, it emits an extra 0 before the next payload bit. As a result the flag pattern 01111110 cannot appear between two flags.

Both sides use a valid/ready handshake and carry one bit per transfer. Bits leave in the same order they arrive. When a stuffed 0 is due, the block places it on the output and lowers the input ready for that cycle, because the output stream is one bit longer than the input stream. A frame-start strobe clears the run state. A per-frame count of inserted bits is available on an output. Flags, removal of stuffed bits and CRC generation are handled elsewhere.

Top module: `bitstuff_inserter`

## Requirements
- R1: After RUN_LEN consecutive 1s (default 5) have been transferred on the output, the next output transfer is a 0 that was not taken from the input. The next payload bit follows that 0.
- R2: While a stuffed 0 is owed, outValid is 1, outBit is 0 and inReady is 0, whatever the input does.
- R3: The ones-run count restarts at zero when a stuffed 0 is transferred and when a payload 0 is transferred. A run of exactly ten 1s followed by a 0 produces 1111101111100, with one inserted 0 after the fifth 1 and one after the tenth.
- R4: Within a frame, the output stream never carries more than RUN_LEN consecutive 1s, so the flag 01111110 never forms in it.
- R5: The payload 01111110 produces the output 011111010, with exactly one insertion.
- R6: When no stuffed 0 is owed, the payload passes straight through in the same cycle: outValid equals inValid, outBit equals inBit, and inReady equals outReady.
- R7: While outReady is 0, no transfer takes place. The run count and stuffCount hold their values, and an owed stuffed 0 stays on the output.
- R8: stuffCount increases by one for each stuffed 0 that is transferred and saturates at 2^CNT_W-1.
- R9: A cycle with frameStart high clears stuffCount and the run count and drops any owed stuffed 0. A payload bit transferred in that same cycle does not count toward the new run.
- R10: After reset, stuffCount is 0 and no stuffed 0 is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Clears per-frame state |
| inValid | input | 1 | Payload bit offered |
| inBit | input | 1 | Payload bit |
| inReady | output | 1 | Payload bit accepted when high with inValid |
| outValid | output | 1 | Output bit offered |
| outBit | output | 1 | Output bit, payload or stuffed 0 |
| outReady | input | 1 | Downstream accepts the output bit |
| stuffCount | output | CNT_W | Stuffed bits inserted in this frame |

## Verification
The bench builds the block with RUN_LEN at 5 and CNT_W reduced to 3. The narrow counter lets a single frame of forty 1s drive stuffCount into saturation. Random traffic biased toward 1s produces long runs, back-pressure from outReady held low during an owed stuffed 0, and frame-start strobes that arrive mid-run. The directed payloads reproduce the flag-shaped byte and the ten-ones case, so the exact positions of the inserted 0s can be compared bit by bit.

// File: rtl/bitstuff_pkg.sv
package bitstuff_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic stuffSel;  // a stuffed 0 is owed this cycle
    logic countInc;  // a stuffed 0 transfers this cycle
    logic countClr;  // frame start
  } stuff_strobe_t;
endpackage

// File: rtl/bitstuff_ctrl.sv
module bitstuff_ctrl
  import bitstuff_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frameStart,
  input  logic          inValid,
  input  logic          inBit,
  input  logic          outReady,
  output stuff_strobe_t strobe
);
  localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] LAST_ONE = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] onesRun;
  logic             stuffOwed;
  logic             payloadFire;
  logic             stuffFire;

  assign payloadFire = !stuffOwed && inValid && outReady;
  assign stuffFire   = stuffOwed && outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesRun   <= '0;
      stuffOwed <= 1'b0;
    end else if (frameStart) begin
      onesRun   <= '0;
      stuffOwed <= 1'b0;
    end else if (stuffFire) begin
      onesRun   <= '0;
      stuffOwed <= 1'b0;
    end else if (payloadFire) begin
      if (!inBit) begin
        onesRun <= '0;
      end else if (onesRun == LAST_ONE) begin
        onesRun   <= '0;
        stuffOwed <= 1'b1;
      end else begin
        onesRun <= onesRun + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.stuffSel = stuffOwed;
    strobe.countInc = stuffFire;
    strobe.countClr = frameStart;
  end
endmodule

// File: rtl/bitstuff_dp.sv
module bitstuff_dp
  import bitstuff_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stuff_strobe_t    strobe,
  input  logic             inValid,
  input  logic             inBit,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outBit,
  output logic [CNT_W-1:0] stuffCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign outValid = strobe.stuffSel ? 1'b1 : inValid;
  assign outBit   = strobe.stuffSel ? 1'b0 : inBit;
  assign inReady  = !strobe.stuffSel && outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stuffCount <= '0;
    end else if (strobe.countClr) begin
      stuffCount <= '0;
    end else if (strobe.countInc && stuffCount != CNT_MAX) begin
      stuffCount <= stuffCount + 1'b1;
    end
  end
endmodule

// File: rtl/bitstuff_inserter.sv
module bitstuff_inserter
  import bitstuff_pkg::*;
#(
  parameter int RUN_LEN = 5,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             inValid,
  input  logic             inBit,
  output logic             inReady,
  output logic             outValid,
  output logic             outBit,
  input  logic             outReady,
  output logic [CNT_W-1:0] stuffCount
);
  stuff_strobe_t strobe;

  bitstuff_ctrl #(.RUN_LEN(RUN_LEN)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .inValid(inValid), .inBit(inBit), .outReady(outReady),
    .strobe(strobe)
  );

  bitstuff_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inValid(inValid), .inBit(inBit), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outBit(outBit),
    .stuffCount(stuffCount)
  );
endmodule

// File: rtl/bitstuff_inserter_chk.sv
module bitstuff_inserter_chk #(
  parameter int RUN_LEN = 5,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frameStart,
  input logic             inValid,
  input logic             inBit,
  input logic             inReady,
  input logic             outValid,
  input logic             outBit,
  input logic             outReady,
  input logic [CNT_W-1:0] stuffCount
);
  localparam int OBS_W = $clog2(RUN_LEN + 2);
  logic [OBS_W-1:0] obsRun;

  // ones seen on the output since the last 0 or frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obsRun <= '0;
    else if (frameStart) obsRun <= '0;
    else if (outValid && outReady) obsRun <= outBit ? obsRun + 1'b1 : '0;
  end

  AST_ZERO_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && obsRun == OBS_W'(RUN_LEN)) |-> (!outBit && !inReady)); // R1
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    obsRun <= OBS_W'(RUN_LEN)); // R4
  AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (outReady && !inReady) |-> (outValid && !outBit)); // R2
  AST_READY_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> outReady); // R6
  AST_STUFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outBit && !outReady && !inValid && !frameStart) |=> (outValid && !outBit)); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!outReady && !frameStart) |=> $stable(stuffCount)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> (stuffCount == $past(stuffCount) || stuffCount == $past(stuffCount) + 1'b1)); // R8
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (stuffCount == '0)); // R9
endmodule

bind bitstuff_inserter bitstuff_inserter_chk #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .inValid(inValid),
  .inBit(inBit), .inReady(inReady), .outValid(outValid), .outBit(outBit),
  .outReady(outReady), .stuffCount(stuffCount)
);

// File: tb/test_bitstuff_inserter.sv
module test_bitstuff_inserter;
  localparam int RUN_LEN = 5;
  localparam int CNT_W   = 3;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0, inValid = 1'b0, inBit = 1'b0, outReady = 1'b0;
  logic inReady, outValid, outBit;
  logic [CNT_W-1:0] stuffCount;

  int checks = 0, errors = 0;
  int mRun = 0, mCount = 0;
  bit mOwed = 0;
  int outRun = 0;
  bit logBits[0:63];
  int logN = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitstuff_inserter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) i_bitstuff_inserter (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .inValid(inValid),
    .inBit(inBit), .inReady(inReady), .outValid(outValid), .outBit(outBit),
    .outReady(outReady), .stuffCount(stuffCount)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare, then advance the model
  task automatic step(bit v, bit b, bit r, bit fs);
    bit xfer, obit;
    @(negedge clk);
    frameStart = fs; inValid = v; inBit = b; outReady = r;
    #3;
    check("R6/R2 outValid", outValid, mOwed ? 1 : v);
    check("R6/R2 outBit", outBit, mOwed ? 0 : b);
    check("R6/R2 inReady", inReady, (!mOwed && r) ? 1 : 0);
    check("R8 stuffCount", stuffCount, mCount);
    xfer = outValid && r;
    obit = outBit;
    if (fs) outRun = 0;
    else if (xfer) begin
      outRun = obit ? outRun + 1 : 0;
      check("R4 output run bound", (outRun > RUN_LEN) ? outRun : 0, 0);
    end
    if (xfer && !fs && logN < 64) begin logBits[logN] = obit; logN++; end
    @(posedge clk);
    if (fs) begin mRun = 0; mOwed = 0; mCount = 0; end
    else if (mOwed && r) begin mOwed = 0; mRun = 0; if (mCount < CMAX) mCount++; end
    else if (!mOwed && v && r) begin
      if (!b) mRun = 0;
      else if (mRun == RUN_LEN - 1) begin mRun = 0; mOwed = 1; end
      else mRun++;
    end
  endtask

  // push payload bits MSB first, waiting through stalls
  task automatic send(logic [31:0] pat, int n);
    for (int i = n - 1; i >= 0; i--) begin
      while (mOwed) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, pat[i], 1'b1, 1'b0);
    end
    while (mOwed) step(1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic expectStream(string tag, logic [31:0] exp, int n);
    check({tag, " length"}, logN, n);
    for (int i = 0; i < n; i++)
      check({tag, " bit"}, logBits[i], exp[n - 1 - i]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #3;
    check("R10 count after reset", stuffCount, 0);
    check("R10 inReady follows outReady", inReady, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);  // frame start, ends the reset test frame

    // R5: flag-shaped payload; R1 stuffed 0 after the fifth 1
    logN = 0;
    send(32'b01111110, 8);
    expectStream("R5 flag payload", 32'b011111010, 9);
    check("R5 one insertion", stuffCount, 1);

    // R3: ten ones then a zero
    step(1'b0, 1'b0, 1'b1, 1'b1);
    logN = 0;
    send(32'b11111111110, 11);
    expectStream("R3 ten ones", 32'b1111101111100, 13);
    check("R3 two insertions", stuffCount, 2);

    // R7: back-pressure while a stuffed 0 is owed
    step(1'b0, 1'b0, 1'b1, 1'b1);
    logN = 0;
    for (int i = 0; i < RUN_LEN; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 count held", stuffCount, 0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    expectStream("R7 R1 stream", 32'b1111100, 7);
    check("R7 count after release", stuffCount, 1);

    // R9: frame start mid-run restarts the run
    step(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    logN = 0;
    send(32'b1111, 4);
    expectStream("R9 no stuff after restart", 32'b1111, 4);
    check("R9 count cleared", stuffCount, 0);

    // R8: saturation with forty ones
    step(1'b0, 1'b0, 1'b1, 1'b1);
    logN = 0;
    send(32'hFFFFFFFF, 32);
    send(32'hFF, 8);
    check("R8 saturated count", stuffCount, CMAX);

    // random traffic biased to ones
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 4) != 0,
           ($urandom % 300) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule